// File: doc/BRIEF.md
# Key-Gated IO Voltage Domain Control Bank

This block holds one control register per dual-voltage pad bank and drives one output bit per bank that selects 1.8 V operation; when that bit is low the bank runs at 3.3 V. Setting a bank to the wrong level can back-power a pad from outside, so the register bank is guarded. Software must first write two fixed key values, in order, into two key registers. That opens the bank for exactly one read or write, after which the block locks itself again.

The block has a single-cycle register-bus slave port. The lower half of the address space is the key window. It holds the first key register at 0x000, the second key register at 0x004 and a violation status register at 0x008. The upper half, starting at 0x100, is the protected window, which spans 0x34 bytes. Inside that window the domain registers sit at offsets 0x0C, 0x10, 0x1C and 0x20, and further domains follow at 0x24, 0x28 and so on. A write takes effect at the clock edge that samples it. Read data is registered.

Top module: `iovd_guard`

## Requirements
- R1: After reset every `dom_v18` bit is 0 (3.3 V), the bank is locked and the status register at 0x008 reads 0.
- R2: Writing 0x0000BABA to 0x000 and then 0x0000EB10 to 0x004 unlocks the bank. A following write to domain offset k (0x0C, 0x10, 0x1C or 0x20 for domains 0 to 3) sets `dom_v18[k]` to bit 2 of the written data, starting the cycle after the write. The same write path can return a bit to 0.
- R3: The unlock is spent by the first protected-window access, whether a read or a write. A second protected access made without new keys is dropped.
- R4: Any of the following clears a partial unlock, so that the next protected access is dropped: a wrong value written to 0x000, a write to 0x004 with a wrong value, or a write to 0x004 not directly preceded by a correct first key. A protected access made while only the first key is in place is also denied, and it clears the partial unlock.
- R5: While the bank is locked, a protected write leaves `dom_v18` unchanged and a protected read returns 0. Either kind of attempt sets bit 0 of the status register at 0x008. Writing 1 to that bit clears it, and the flag is sticky until then.
- R6: A granted read of a domain register returns only bit 2, holding the 1.8 V enable. Every reserved bit reads 0 whatever was written to it.
- R7: An access to an undefined offset inside the protected window (for example 0x00) returns 0 and still spends the unlock.
- R8: Reads of 0x000 and 0x004 return 0, and a read of a key register does not change the unlock state.
- R9: `bus_rdata` carries read data in the cycle after a read request is sampled, and it is 0 in the cycle after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (9) | Byte address; the top bit selects the protected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dom_v18 | output | N_DOM (4) | 1.8 V enable per pad bank |

## Verification
Read data is due one cycle after the edge that samples the request. The bench drives each request at a falling edge and records the expected word in a queue. Its monitor samples bus_rdata 2 ns after the next rising edge and compares it with the queued word. A domain write shows on dom_v18 directly after the sampling edge, and the violation flag is visible to a read issued in the following cycle. The bench therefore checks dom_v18 at the falling edge after each write, and it checks the flag with a read placed after the denied access.

// File: rtl/iovd_pkg.sv
package iovd_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_e;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_BABA;
  localparam logic [31:0] KEY_SECOND = 32'h0000_EB10;
  localparam int          V18_BIT    = 2;
  localparam int          PROT_SPAN  = 'h34;

  // Byte offset of domain i inside the protected window.
  function automatic int dom_ofs(int i);
    case (i)
      0:       return 'h0C;
      1:       return 'h10;
      2:       return 'h1C;
      3:       return 'h20;
      default: return 'h24 + 4 * (i - 4);
    endcase
  endfunction

  // Read-back word of a domain register: only the enable bit is live.
  function automatic logic [31:0] dom_word(logic en);
    logic [31:0] w;
    w = '0;
    w[V18_BIT] = en;
    return w;
  endfunction

endpackage

// File: rtl/iovd_key_fsm.sv
module iovd_key_fsm
  import iovd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      key_a_wr,
  input  logic      key_a_ok,
  input  logic      key_b_wr,
  input  logic      key_b_ok,
  input  logic      prot_acc,
  output lk_state_e state,
  output logic      grant
);

  lk_state_e nxt;

  assign grant = prot_acc && (state == LK_OPEN);

  always_comb begin
    nxt = state;
    if (prot_acc)      nxt = LK_SHUT;
    else if (key_a_wr) nxt = key_a_ok ? LK_HALF : LK_SHUT;
    else if (key_b_wr) nxt = (key_b_ok && state == LK_HALF) ? LK_OPEN : LK_SHUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LK_SHUT;
    else        state <= nxt;
  end

endmodule

// File: rtl/iovd_dom_bank.sv
module iovd_dom_bank
  import iovd_pkg::*;
#(
  parameter int N_DOM = 4,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic             wr_bit,
  output logic [N_DOM-1:0] v18,
  output logic             rd_bit,
  output logic             hit
);

  logic [N_DOM-1:0] sel;

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    assign sel[g] = (int'(ofs) == dom_ofs(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 v18[g] <= 1'b0;
      else if (wr_en && sel[g])   v18[g] <= wr_bit;
    end
  end

  assign hit    = |sel;
  assign rd_bit = |(sel & v18);

endmodule

// File: rtl/iovd_guard.sv
module iovd_guard
  import iovd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int N_DOM  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_DOM-1:0]  dom_v18
);

  localparam int OFS_W = ADDR_W - 1;

  logic [OFS_W-1:0] ofs;
  logic in_prot, in_key;
  logic key_a_wr, key_b_wr, key_b_hit, key_rd, stat_rd, stat_wr;
  logic prot_acc, prot_grant, prot_deny, prot_rd;
  logic dom_hit, dom_rd_bit, viol;
  lk_state_e lk_state;
  logic [31:0] rd_nxt;

  assign ofs     = bus_addr[OFS_W-1:0];
  assign in_prot = bus_sel && bus_addr[ADDR_W-1] && (int'(ofs) < PROT_SPAN);
  assign in_key  = bus_sel && !bus_addr[ADDR_W-1];

  assign key_a_wr  = in_key && bus_wr && (int'(ofs) == 'h00);
  assign key_b_wr  = in_key && bus_wr && (int'(ofs) == 'h04);
  assign key_b_hit = key_b_wr && (bus_wdata == KEY_SECOND);
  assign key_rd    = in_key && !bus_wr && (int'(ofs) == 'h00 || int'(ofs) == 'h04);
  assign stat_rd   = in_key && !bus_wr && (int'(ofs) == 'h08);
  assign stat_wr   = in_key && bus_wr && (int'(ofs) == 'h08);

  assign prot_acc  = in_prot;
  assign prot_deny = prot_acc && !prot_grant;
  assign prot_rd   = prot_acc && !bus_wr;

  iovd_key_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_a_wr (key_a_wr),
    .key_a_ok (bus_wdata == KEY_FIRST),
    .key_b_wr (key_b_wr),
    .key_b_ok (bus_wdata == KEY_SECOND),
    .prot_acc (prot_acc),
    .state    (lk_state),
    .grant    (prot_grant)
  );

  iovd_dom_bank #(.N_DOM(N_DOM), .OFS_W(OFS_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (prot_grant && bus_wr),
    .ofs    (ofs),
    .wr_bit (bus_wdata[V18_BIT]),
    .v18    (dom_v18),
    .rd_bit (dom_rd_bit),
    .hit    (dom_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        viol <= 1'b0;
    else if (prot_deny)                viol <= 1'b1;
    else if (stat_wr && bus_wdata[0])  viol <= 1'b0;
  end

  always_comb begin
    rd_nxt = '0;
    if (stat_rd)                             rd_nxt = {31'b0, viol};
    else if (prot_rd && prot_grant && dom_hit) rd_nxt = dom_word(dom_rd_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/iovd_guard_chk.sv
module iovd_guard_chk
  import iovd_pkg::*;
#(
  parameter int N_DOM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [31:0]      bus_rdata,
  input logic [N_DOM-1:0] dom_v18,
  input lk_state_e        lk_state,
  input logic             key_b_hit,
  input logic             prot_acc,
  input logic             prot_deny,
  input logic             prot_rd,
  input logic             key_rd,
  input logic             viol
);

  a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_b_hit && lk_state == LK_HALF) |=> (lk_state == LK_OPEN));

  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    prot_acc |=> (lk_state == LK_SHUT));

  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    prot_deny |=> $stable(dom_v18));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_deny |=> viol);

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    prot_rd |=> ((bus_rdata & ~32'h4) == 32'h0));

  a_r8_key_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd |=> (bus_rdata == 32'h0));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> (bus_rdata == 32'h0));

endmodule

bind iovd_guard iovd_guard_chk #(.N_DOM(N_DOM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .dom_v18   (dom_v18),
  .lk_state  (lk_state),
  .key_b_hit (key_b_hit),
  .prot_acc  (prot_acc),
  .prot_deny (prot_deny),
  .prot_rd   (prot_rd),
  .key_rd    (key_rd),
  .viol      (viol)
);

// File: tb/sim_iovd_guard.sv
`timescale 1ns/1ps
module sim_iovd_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  dom_v18;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  iovd_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dom_v18(dom_v18)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic unlock();
    wr(9'h000, 32'h0000_BABA);
    wr(9'h004, 32'h0000_EB10);
  endtask

  // Monitor: a read sampled at an edge is compared 2 ns after that edge.
  always @(posedge clk) begin
    logic was_rd;
    was_rd = bus_sel && !bus_wr && rst_n;
    #2;
    if (was_rd) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: read result with no expected item");
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 dom_v18 after reset", {28'b0, dom_v18}, 32'h0);
    rd(9'h008, 32'h0, "R1 status after reset");
    idle();
    chk("R9 rdata zero after idle", bus_rdata, 32'h0);

    // R2: unlock then write domain 2 with all bits set
    unlock();
    wr(9'h11C, 32'hFFFF_FFFF);
    idle();
    chk("R2 domain 2 set", {28'b0, dom_v18}, 32'h4);

    // R6: granted read returns only bit 2
    unlock();
    rd(9'h11C, 32'h4, "R6 domain read reserved zero");
    idle();

    // R3: second access without keys is dropped
    unlock();
    wr(9'h10C, 32'h4);
    wr(9'h110, 32'h4);
    idle();
    chk("R3 one shot", {28'b0, dom_v18}, 32'h5);

    // R5: violation flag set by the dropped write, then cleared
    rd(9'h008, 32'h1, "R5 violation set");
    wr(9'h008, 32'h1);
    rd(9'h008, 32'h0, "R5 violation cleared");
    rd(9'h110, 32'h0, "R5 locked read zero");
    rd(9'h008, 32'h1, "R5 locked read flagged");
    wr(9'h008, 32'h1);
    idle();

    // R4: wrong first key
    wr(9'h000, 32'h0000_BABB);
    wr(9'h004, 32'h0000_EB10);
    wr(9'h120, 32'h4);
    idle();
    chk("R4 wrong first key", {28'b0, dom_v18}, 32'h5);
    // R4: second key alone
    wr(9'h004, 32'h0000_EB10);
    wr(9'h120, 32'h4);
    idle();
    chk("R4 second key alone", {28'b0, dom_v18}, 32'h5);
    // R4: wrong second key value
    wr(9'h000, 32'h0000_BABA);
    wr(9'h004, 32'h0000_EB11);
    wr(9'h120, 32'h4);
    idle();
    chk("R4 wrong second key", {28'b0, dom_v18}, 32'h5);
    // R4: access with only the first key, then second key must not open
    wr(9'h000, 32'h0000_BABA);
    wr(9'h120, 32'h4);
    wr(9'h004, 32'h0000_EB10);
    wr(9'h120, 32'h4);
    idle();
    chk("R4 half unlock denied", {28'b0, dom_v18}, 32'h5);
    wr(9'h008, 32'h1);

    // R7: undefined offset spends the unlock
    unlock();
    rd(9'h100, 32'h0, "R7 undefined offset reads zero");
    wr(9'h120, 32'h4);
    idle();
    chk("R7 unlock spent", {28'b0, dom_v18}, 32'h5);
    wr(9'h008, 32'h1);

    // R8: key registers read zero and do not disturb the sequence
    wr(9'h000, 32'h0000_BABA);
    rd(9'h000, 32'h0, "R8 first key reads zero");
    wr(9'h004, 32'h0000_EB10);
    rd(9'h004, 32'h0, "R8 second key reads zero");
    wr(9'h120, 32'h4);
    idle();
    chk("R8 key read harmless", {28'b0, dom_v18}, 32'hD);

    // R2: clearing a domain back to 3.3 V
    unlock();
    wr(9'h11C, 32'h0);
    idle();
    chk("R2 domain 2 cleared", {28'b0, dom_v18}, 32'h9);
    rd(9'h008, 32'h0, "R5 no violation on granted accesses");
    idle();
    idle();
    chk("R9 rdata zero after read", bus_rdata, 32'h0);

    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9: %0d reads never answered, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule